// File: doc/BRIEF.md
# UART task/event register controller

This block is the register-side controller of a byte-wide UART. Software drives it through a 32-bit, word-addressed read/write port. Control works by tasks and events. Writing the value 1 to a task register starts or stops a direction. Event registers are flags that stay set until software clears them. An interrupt-enable mask chooses which events drive the single level interrupt.

On the line side, a byte transmit port and a byte receive port each use a valid/ready handshake, and a break input reports a line break. Received bytes collect in a small circular FIFO, which software drains by reading the receive-data register. The serial shifter, the baud generator and the pin multiplexing sit outside this block. The four pin-select words and the baud word are only stored and read back.

Read data is combinational from the address in the same cycle. Every write and every read side effect takes hold at the next rising clock edge.

Top module: `uart_evt_ctrl`

## Requirements
- R1: `irq` is high exactly when some event flag is set and its mask bit is also set. The mask bits are: bit0 RX-ready, bit1 TX-ready, bit2 error, bit3 RX-timeout.
- R2: While the block is disabled, `bus_rdata` is zero and writes to any address other than ENABLE (word 24) change nothing.
- R3: Writing 4 to ENABLE (word 24) enables the block. Writing 0 disables it, stops transmit and receive, and sets RX-timeout. Any other value has no effect.
- R4: MASK (word 16) replaces the mask. MASKSET (word 17) ORs bits into it. MASKCLR (word 18) clears the bits written as 1. All three words read back the mask.
- R5: A write to TXD (word 26) is taken only when transmit is started and no byte is pending. The pending byte is held on `tx_data` with `tx_valid` high until `tx_ready`. When the handshake completes, the pending flag clears and the TX-ready event (word 9) is set.
- R6: A read of RXD (word 25) returns the FIFO head. If receive is started and the FIFO is not empty, the read also pops the head, and it sets RX-ready (word 8) again when bytes remain.
- R7: Writing 1 to STOPRX (word 1) stops receive and sets RX-timeout (word 11). Writing 1 to STOPTX (word 3) stops only transmit. Writing 1 to SUSPEND (word 4) stops both directions and sets RX-timeout. STARTRX (word 0) and STARTTX (word 2) start a direction on a write of 1. Task writes of any other value are ignored.
- R8: ERRSRC (word 20) clears the bits written as 1. A `brk_in` cycle sets ERRSRC bits 1:0 and the error event (word 10).
- R9: Writing 0 to RX-ready clears it, and a nonzero write to it is ignored. The TX-ready, error and RX-timeout flags take the value 1 on a nonzero write and 0 on a zero write. Event words read back as 0 or 1.
- R10: After reset, PINSEL0..3 (words 28..31) read all ones, BAUD (word 32) reads 0x04000000, and all other state is clear.
- R11: `rx_ready` is high only while receive is started and the FIFO (FIFO_DEPTH bytes, default 6) has room. Each accepted byte is appended at the tail and sets RX-ready.
- R12: When a bus write to an event register or to ERRSRC falls in the same cycle as a line-side update of that register, the bus write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the RXD pop side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | A transmit byte is pending |
| tx_ready | input | 1 | Line side takes the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive FIFO accepts a byte |
| brk_in | input | 1 | Line break seen in this cycle |
| irq | output | 1 | Level interrupt |

## Verification
Two updates can reach the same register in one cycle: a line-side event (a received byte, or a break) and a software write to that event flag or to ERRSRC. The bench provokes the collision by driving `rx_valid` together with a zero write to RX-ready, and by driving `brk_in` together with a zero write to ERRSRC, both on the same clock edge. It then reads back RX-ready as 0 and ERRSRC as 0, because the bus write must win. It also reads the received byte out of RXD, to confirm the push itself was not lost.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int ADDR_W = 6;
  localparam int NUM_EV = 4;

  localparam logic [ADDR_W-1:0] A_STARTRX = 6'd0;
  localparam logic [ADDR_W-1:0] A_STOPRX  = 6'd1;
  localparam logic [ADDR_W-1:0] A_STARTTX = 6'd2;
  localparam logic [ADDR_W-1:0] A_STOPTX  = 6'd3;
  localparam logic [ADDR_W-1:0] A_SUSPEND = 6'd4;
  localparam logic [ADDR_W-1:0] A_EV_RXRDY = 6'd8;
  localparam logic [ADDR_W-1:0] A_EV_TXRDY = 6'd9;
  localparam logic [ADDR_W-1:0] A_EV_ERR   = 6'd10;
  localparam logic [ADDR_W-1:0] A_EV_RXTO  = 6'd11;
  localparam logic [ADDR_W-1:0] A_MASK    = 6'd16;
  localparam logic [ADDR_W-1:0] A_MASKSET = 6'd17;
  localparam logic [ADDR_W-1:0] A_MASKCLR = 6'd18;
  localparam logic [ADDR_W-1:0] A_ERRSRC  = 6'd20;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 6'd24;
  localparam logic [ADDR_W-1:0] A_RXD     = 6'd25;
  localparam logic [ADDR_W-1:0] A_TXD     = 6'd26;
  localparam logic [ADDR_W-1:0] A_PINSEL0 = 6'd28;
  localparam logic [ADDR_W-1:0] A_BAUD    = 6'd32;

  localparam int EV_RXRDY = 0;
  localparam int EV_TXRDY = 1;
  localparam int EV_ERR   = 2;
  localparam int EV_RXTO  = 3;

  localparam logic [31:0] ENABLE_KEY = 32'd4;

  // position after stepping a ring pointer
  function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                           int unsigned depth);
    return (base + step) % depth;
  endfunction

  // fill level after one cycle of push/pop
  function automatic int unsigned level_next(int unsigned level, logic push, logic pop);
    return level + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/uart_evt_rxfifo.sv
module uart_evt_rxfifo
  import uart_evt_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [7:0]                push_byte,
  input  logic                      pop,
  output logic [7:0]                head_byte,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                      full,
  output logic                      empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] tail_w;

  assign tail_w    = PW'(ring_add(32'(head_q), 32'(cnt_q), DEPTH));
  assign head_byte = mem_q[head_q];
  assign level     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) mem_q[tail_w] <= push_byte;
      if (pop) head_q <= PW'(ring_add(32'(head_q), 1, DEPTH));
      cnt_q <= CW'(level_next(32'(cnt_q), push, pop));
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/uart_evt_txhold.sv
module uart_evt_txhold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       tx_on,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       done_evt
);
  logic       pend_q;
  logic [7:0] byte_q;
  logic       accept_evt;

  assign accept_evt = load && tx_on && !pend_q;
  assign done_evt   = pend_q && tx_ready;
  assign tx_valid   = pend_q;
  assign tx_data    = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      byte_q <= '0;
    end else begin
      if (accept_evt) begin
        pend_q <= 1'b1;
        byte_q <= load_byte;
      end else if (done_evt) begin
        pend_q <= 1'b0;
      end
    end
  end

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_tx_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !tx_valid);
endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq #(
  parameter int NEV = 4
) (
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] mask,
  output logic           irq
);
  logic [NEV-1:0] hit;
  for (genvar g = 0; g < NEV; g++) begin : g_hit
    assign hit[g] = ev[g] & mask[g];
  end
  assign irq = |hit;
endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
  import uart_evt_pkg::*;
#(
  parameter int          FIFO_DEPTH = 6,
  parameter int          NUM_PINSEL = 4,
  parameter logic [31:0] BAUD_RST   = 32'h0400_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              brk_in,
  output logic              irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic              en_q, rx_on_q, tx_on_q;
  logic [NUM_EV-1:0] ev_q, mask_q;
  logic [1:0]        errsrc_q;
  logic [31:0]       baud_q;
  logic [31:0]       pinsel_q [NUM_PINSEL];

  logic wr_ok, rd_ok, w_one, w_zero;
  logic wr_evrx, wr_evtx, wr_everr, wr_evto, wr_errsrc, wr_en;
  logic start_rx, start_tx, stop_rx_evt, stop_tx_evt;
  logic push_evt, pop_evt, rearm_evt, tx_done_evt, tx_load;
  logic [7:0]    head_byte;
  logic [CW-1:0] fifo_level;
  logic          fifo_full, fifo_empty;

  assign wr_ok  = bus_wr && (en_q || bus_addr == A_ENABLE);
  assign rd_ok  = bus_rd && en_q;
  assign w_one  = (bus_wdata == 32'd1);
  assign w_zero = (bus_wdata == 32'd0);

  assign wr_evrx   = wr_ok && bus_addr == A_EV_RXRDY;
  assign wr_evtx   = wr_ok && bus_addr == A_EV_TXRDY;
  assign wr_everr  = wr_ok && bus_addr == A_EV_ERR;
  assign wr_evto   = wr_ok && bus_addr == A_EV_RXTO;
  assign wr_errsrc = wr_ok && bus_addr == A_ERRSRC;
  assign wr_en     = wr_ok && bus_addr == A_ENABLE;
  assign tx_load   = wr_ok && bus_addr == A_TXD;

  assign start_rx    = wr_ok && bus_addr == A_STARTRX && w_one;
  assign start_tx    = wr_ok && bus_addr == A_STARTTX && w_one;
  assign stop_rx_evt = (wr_ok && w_one && (bus_addr == A_STOPRX || bus_addr == A_SUSPEND))
                       || (wr_en && w_zero);
  assign stop_tx_evt = (wr_ok && w_one && (bus_addr == A_STOPTX || bus_addr == A_SUSPEND))
                       || (wr_en && w_zero);

  assign rx_ready  = rx_on_q && !fifo_full;
  assign push_evt  = rx_valid && rx_ready;
  assign pop_evt   = rd_ok && bus_addr == A_RXD && rx_on_q && !fifo_empty;
  assign rearm_evt = pop_evt && (fifo_level > CW'(1));

  uart_evt_rxfifo #(.DEPTH(FIFO_DEPTH)) u_rxfifo (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .push_byte(rx_data),
    .pop(pop_evt), .head_byte(head_byte), .level(fifo_level),
    .full(fifo_full), .empty(fifo_empty)
  );

  uart_evt_txhold u_txhold (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_byte(bus_wdata[7:0]),
    .tx_on(tx_on_q), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .done_evt(tx_done_evt)
  );

  uart_evt_irq #(.NEV(NUM_EV)) u_irq (.ev(ev_q), .mask(mask_q), .irq(irq));

  // control and event state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rx_on_q  <= 1'b0;
      tx_on_q  <= 1'b0;
      ev_q     <= '0;
      mask_q   <= '0;
      errsrc_q <= '0;
      baud_q   <= BAUD_RST;
    end else begin
      if (wr_en) begin
        if (bus_wdata == ENABLE_KEY) en_q <= 1'b1;
        else if (w_zero)             en_q <= 1'b0;
      end
      if (stop_rx_evt)   rx_on_q <= 1'b0;
      else if (start_rx) rx_on_q <= 1'b1;
      if (stop_tx_evt)   tx_on_q <= 1'b0;
      else if (start_tx) tx_on_q <= 1'b1;

      if (wr_evrx) begin
        if (w_zero) ev_q[EV_RXRDY] <= 1'b0;
      end else if (push_evt || rearm_evt) begin
        ev_q[EV_RXRDY] <= 1'b1;
      end
      if (wr_evtx)          ev_q[EV_TXRDY] <= !w_zero;
      else if (tx_done_evt) ev_q[EV_TXRDY] <= 1'b1;
      if (wr_everr)         ev_q[EV_ERR] <= !w_zero;
      else if (brk_in)      ev_q[EV_ERR] <= 1'b1;
      if (wr_evto)          ev_q[EV_RXTO] <= !w_zero;
      else if (stop_rx_evt) ev_q[EV_RXTO] <= 1'b1;

      if (wr_errsrc)   errsrc_q <= errsrc_q & ~bus_wdata[1:0];
      else if (brk_in) errsrc_q <= 2'b11;

      if (wr_ok && bus_addr == A_MASK)         mask_q <= bus_wdata[NUM_EV-1:0];
      else if (wr_ok && bus_addr == A_MASKSET) mask_q <= mask_q | bus_wdata[NUM_EV-1:0];
      else if (wr_ok && bus_addr == A_MASKCLR) mask_q <= mask_q & ~bus_wdata[NUM_EV-1:0];

      if (wr_ok && bus_addr == A_BAUD) baud_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NUM_PINSEL; g++) begin : g_pinsel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pinsel_q[g] <= '1;
      else if (wr_ok && bus_addr == A_PINSEL0 + ADDR_W'(g)) pinsel_q[g] <= bus_wdata;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (en_q) begin
      case (bus_addr)
        A_EV_RXRDY: bus_rdata = {31'd0, ev_q[EV_RXRDY]};
        A_EV_TXRDY: bus_rdata = {31'd0, ev_q[EV_TXRDY]};
        A_EV_ERR:   bus_rdata = {31'd0, ev_q[EV_ERR]};
        A_EV_RXTO:  bus_rdata = {31'd0, ev_q[EV_RXTO]};
        A_MASK, A_MASKSET, A_MASKCLR: bus_rdata = {{(32-NUM_EV){1'b0}}, mask_q};
        A_ERRSRC:   bus_rdata = {30'd0, errsrc_q};
        A_ENABLE:   bus_rdata = ENABLE_KEY;
        A_RXD:      bus_rdata = {24'd0, head_byte};
        A_TXD:      bus_rdata = {24'd0, tx_data};
        A_BAUD:     bus_rdata = baud_q;
        default: begin
          for (int i = 0; i < NUM_PINSEL; i++)
            if (bus_addr == A_PINSEL0 + ADDR_W'(i)) bus_rdata = pinsel_q[i];
        end
      endcase
    end
  end

  p_irq_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_q & mask_q)) == irq);
  p_locked_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && bus_wr && bus_addr != A_ENABLE) |=> $stable(mask_q));
  p_enable_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_zero) |=> (!en_q && !rx_on_q && !tx_on_q && ev_q[EV_RXTO]));
  p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_evt && !wr_evrx) |=> ev_q[EV_RXRDY]);
  p_stop_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rx_evt |=> (!rx_on_q && ev_q[EV_RXTO]));
  p_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_in && !wr_errsrc && !wr_everr) |=> (errsrc_q == 2'b11 && ev_q[EV_ERR]));
  p_bus_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evrx && w_zero && push_evt) |=> !ev_q[EV_RXRDY]);
endmodule

// File: tb/uart_evt_ctrl_test.sv
module uart_evt_ctrl_test;
  import uart_evt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        brk_in = 1'b0;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];

  always #2 clk = ~clk;

  uart_evt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .brk_in(brk_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    #1 chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // scoreboard driver for transmit
  task automatic send_tx(input logic [7:0] b, input bit taken);
    wr(A_TXD, {24'd0, b});
    if (taken) exp_tx.push_back(b);
  endtask

  task automatic send_rx(input logic [7:0] b, input bit taken);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    if (taken) exp_rx.push_back(b);
  endtask

  task automatic read_rxd(input bit pops, input string tag);
    logic [7:0] e;
    e = (exp_rx.size() != 0) ? exp_rx[0] : 8'h00;
    rd_chk(A_RXD, {24'd0, e}, tag);
    if (pops && exp_rx.size() != 0) void'(exp_rx.pop_front());
  endtask

  // scoreboard monitor: completed transmit handshakes
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) chk("R5 unexpected tx byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
      else chk("R5 tx byte", {24'd0, tx_data}, {24'd0, exp_tx.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state at the ports
    chk("R10 tx_valid", {31'd0, tx_valid}, 0);
    chk("R10 rx_ready", {31'd0, rx_ready}, 0);
    chk("R10 irq", {31'd0, irq}, 0);
    // R2 locked while disabled
    rd_chk(A_BAUD, 0, "R2 read while disabled");
    wr(A_MASK, 32'hF);
    wr(A_STARTRX, 1);
    chk("R2 start ignored", {31'd0, rx_ready}, 0);
    // R3 wrong key
    wr(A_ENABLE, 5);
    rd_chk(A_BAUD, 0, "R3 bad key");
    wr(A_ENABLE, 4);
    rd_chk(A_BAUD, 32'h0400_0000, "R10 baud");
    for (int i = 0; i < 4; i++) rd_chk(A_PINSEL0 + 6'(i), 32'hFFFF_FFFF, "R10 pinsel");
    rd_chk(A_MASK, 0, "R2 mask untouched");
    rd_chk(A_EV_RXTO, 0, "R10 event clear");
    // R4 mask aliases
    wr(A_MASK, 5);     rd_chk(A_MASK, 5, "R4 replace");
    wr(A_MASKSET, 2);  rd_chk(A_MASKSET, 7, "R4 set");
    wr(A_MASKCLR, 4);  rd_chk(A_MASKCLR, 3, "R4 clear");
    // R5 transmit
    tx_ready = 1'b0;
    send_tx(8'h11, 0);
    chk("R5 not started", {31'd0, tx_valid}, 0);
    wr(A_STARTTX, 1);
    send_tx(8'hA5, 1);
    send_tx(8'h3C, 0);
    chk("R5 pending", {31'd0, tx_valid}, 1);
    chk("R5 held byte", {24'd0, tx_data}, 32'hA5);
    chk("R1 no event yet", {31'd0, irq}, 0);
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R5 drained", {31'd0, tx_valid}, 0);
    chk("R1 irq on TX-ready", {31'd0, irq}, 1);
    rd_chk(A_EV_TXRDY, 1, "R5 TX-ready");
    send_tx(8'h3C, 1);
    @(negedge clk);
    chk("R5 second drained", {31'd0, tx_valid}, 0);
    wr(A_MASKCLR, 2);
    chk("R1 masked", {31'd0, irq}, 0);
    wr(A_MASKSET, 2);
    chk("R1 unmasked", {31'd0, irq}, 1);
    wr(A_EV_TXRDY, 0);
    chk("R9 TX-ready cleared", {31'd0, irq}, 0);
    // R11 receive
    chk("R11 not started", {31'd0, rx_ready}, 0);
    send_rx(8'h77, 0);
    wr(A_STARTRX, 1);
    chk("R11 started", {31'd0, rx_ready}, 1);
    for (int i = 0; i < 6; i++) send_rx(8'h40 + 8'(i), 1);
    chk("R11 full", {31'd0, rx_ready}, 0);
    send_rx(8'h99, 0);
    rd_chk(A_EV_RXRDY, 1, "R11 RX-ready");
    chk("R1 irq on RX-ready", {31'd0, irq}, 1);
    wr(A_EV_RXRDY, 5);
    rd_chk(A_EV_RXRDY, 1, "R9 nonzero ignored");
    wr(A_EV_RXRDY, 0);
    rd_chk(A_EV_RXRDY, 0, "R9 zero clears");
    read_rxd(1, "R6 head");
    rd_chk(A_EV_RXRDY, 1, "R6 re-raised");
    chk("R11 room again", {31'd0, rx_ready}, 1);
    for (int i = 0; i < 5; i++) begin
      wr(A_EV_RXRDY, 0);
      read_rxd(1, "R6 drain");
    end
    rd_chk(A_EV_RXRDY, 0, "R6 last byte no re-raise");
    // R12 collisions
    bus_addr = A_EV_RXRDY; bus_wdata = 0; bus_wr = 1'b1;
    rx_data = 8'h5A; rx_valid = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; rx_valid = 1'b0;
    exp_rx.push_back(8'h5A);
    rd_chk(A_EV_RXRDY, 0, "R12 RX-ready write wins");
    read_rxd(1, "R12 byte kept");
    bus_addr = A_ERRSRC; bus_wdata = 0; bus_wr = 1'b1; brk_in = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; brk_in = 1'b0;
    rd_chk(A_ERRSRC, 0, "R12 ERRSRC write wins");
    rd_chk(A_EV_ERR, 1, "R8 error event");
    // R8 break and W1C
    brk_in = 1'b1;
    @(negedge clk);
    brk_in = 1'b0;
    rd_chk(A_ERRSRC, 3, "R8 break source");
    wr(A_ERRSRC, 1);
    rd_chk(A_ERRSRC, 2, "R8 write-1-clear");
    wr(A_EV_ERR, 0);  rd_chk(A_EV_ERR, 0, "R9 error cleared");
    wr(A_EV_ERR, 7);  rd_chk(A_EV_ERR, 1, "R9 error written");
    // R7 tasks
    wr(A_STOPTX, 1);
    send_tx(8'h22, 0);
    chk("R7 STOPTX blocks TXD", {31'd0, tx_valid}, 0);
    chk("R7 STOPTX leaves rx", {31'd0, rx_ready}, 1);
    wr(A_EV_RXTO, 0);
    wr(A_STOPRX, 2);
    chk("R7 value 2 ignored", {31'd0, rx_ready}, 1);
    send_rx(8'h6B, 1);
    wr(A_STOPRX, 1);
    chk("R7 STOPRX", {31'd0, rx_ready}, 0);
    rd_chk(A_EV_RXTO, 1, "R7 timeout event");
    read_rxd(0, "R6 no pop when stopped");
    read_rxd(0, "R6 head unchanged");
    wr(A_STARTRX, 1);
    read_rxd(1, "R6 pop after restart");
    wr(A_EV_RXTO, 0);
    wr(A_STARTTX, 1);
    wr(A_SUSPEND, 1);
    chk("R7 SUSPEND rx", {31'd0, rx_ready}, 0);
    rd_chk(A_EV_RXTO, 1, "R7 SUSPEND timeout");
    send_tx(8'h33, 0);
    chk("R7 SUSPEND tx", {31'd0, tx_valid}, 0);
    // R3 disable
    wr(A_STARTTX, 1);
    wr(A_STARTRX, 1);
    wr(A_EV_RXTO, 0);
    wr(A_ENABLE, 0);
    chk("R3 disable stops rx", {31'd0, rx_ready}, 0);
    rd_chk(A_BAUD, 0, "R2 disabled read");
    wr(A_ENABLE, 4);
    rd_chk(A_EV_RXTO, 1, "R3 disable sets timeout");
    send_tx(8'h44, 0);
    chk("R3 disable stops tx", {31'd0, tx_valid}, 0);
    repeat (2) @(negedge clk);
    chk("R5 scoreboard empty", exp_tx.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule